// File: doc/BRIEF.md
# Two-Byte DAC Write Sequencer

This block sits on the host side of a byte-wide current-output DAC that has a double-buffered register pair. It takes one 16-bit code at a time over a valid/ready handshake and turns it into a fixed pin sequence. First the low byte is written with byte-select low. Then the high byte is written with byte-select high. Last comes a single active-low load pulse that moves the assembled word into the converter's output register.

Every minimum interval the converter needs is a parameter given in nanoseconds and converted, with round-up, into a count of system clocks. These intervals are byte-select setup and hold, data setup to the write rising edge, write strobe width and load width. Each phase lasts exactly its clock count. Between words the sequencer holds the write and load strobes high, keeps the clear line inactive, and leaves the last data byte and byte-select on the bus. A one-cycle done pulse marks the end of each word.

Top module: `dac_byte_writer`

## Requirements
- R1: After a synchronous reset, dac_wr_n, dac_ld_n and dac_clr_n are 1, dac_data is 0, in_ready is 1, and busy and done are 0.
- R2: A word is accepted on a rising edge where in_valid and in_ready are both 1. From the next cycle in_ready is 0 and busy is 1 for exactly 1+W+1+1+W+1+L cycles, where W is the strobe count and L is the load count (43 cycles at an 8 ns clock). in_ready returns to 1 in the same cycle that dac_ld_n returns high. A request held high at that moment is accepted on the next edge.
- R3: Each word produces exactly two write strobes, the first with dac_hi_sel = 0 carrying code[7:0] and the second with dac_hi_sel = 1 carrying code[15:8]. These are followed by one load pulse, which starts while dac_hi_sel = 1 and dac_wr_n = 1.
- R4: dac_wr_n is low for exactly max(ceil(80 ns), ceil(80 ns data setup)) clock periods per strobe (10 cycles at 8 ns).
- R5: dac_data is stable during the setup cycle and the whole strobe, which is at least 10 cycles before the rising edge of dac_wr_n. It also stays stable for at least one cycle after that rising edge.
- R6: dac_hi_sel is settled at least one cycle before dac_wr_n falls and holds until at least one cycle after dac_wr_n rises. It never changes while dac_wr_n is low.
- R7: dac_ld_n is low for exactly ceil(150 ns) clock periods (19 cycles at 8 ns). It begins one cycle after the final write rising edge and is never low together with dac_wr_n.
- R8: done is a single-cycle pulse in the cycle dac_ld_n returns high.
- R9: dac_clr_n is always 1. While idle, dac_wr_n and dac_ld_n stay 1, and dac_data and dac_hi_sel keep the values from the last phase (the high byte, with select 1).
- R10: Changes on in_code and in_valid while busy do not affect the word in flight. A request withdrawn before in_ready returns starts no transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Host offers a code |
| in_ready | output | 1 | Sequencer can accept a code |
| in_code | input | 2*BYTE_W | Code to transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at end of transfer |
| dac_data | output | BYTE_W | Byte bus to the converter |
| dac_wr_n | output | 1 | Active-low write strobe |
| dac_hi_sel | output | 1 | Byte select, 1 = high byte |
| dac_ld_n | output | 1 | Active-low load strobe |
| dac_clr_n | output | 1 | Active-low clear, held inactive |

## Verification
The bound checker watches, on every cycle, the exact widths of each write and load pulse, the stability of data and byte-select around every strobe edge, the mutual exclusion of write and load, the single-cycle done pulse, and the idle hold of the bus. The ordering of low byte before high byte, the total busy length, and the correct word reaching the converter's output register are only shown by the bench's scenarios. These scenarios are edge codes, back-to-back requests, and requests or code changes made while busy; the bench checks them through a behavioural model of the converter's two register stages.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LO_SETUP,
        ST_LO_STROBE,
        ST_LO_HOLD,
        ST_HI_SETUP,
        ST_HI_STROBE,
        ST_HI_HOLD,
        ST_LOAD
    } seq_state_t;

    // Pin intent for one phase; drive = bus and select follow the phase
    typedef struct packed {
        logic wr_n;
        logic ld_n;
        logic hi_sel;
        logic drive;
    } pin_ctl_t;

    // Nanoseconds to clocks, rounded up, never below one clock
    function automatic int ns_to_clocks(input int ns, input int period_ps);
        int c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic pin_ctl_t pin_decode(input seq_state_t s);
        pin_ctl_t p;
        p = '{wr_n: 1'b1, ld_n: 1'b1, hi_sel: 1'b0, drive: 1'b0};
        case (s)
            ST_LO_SETUP, ST_LO_HOLD: p.drive = 1'b1;
            ST_LO_STROBE: begin
                p.drive = 1'b1;
                p.wr_n  = 1'b0;
            end
            ST_HI_SETUP, ST_HI_HOLD: begin
                p.drive  = 1'b1;
                p.hi_sel = 1'b1;
            end
            ST_HI_STROBE: begin
                p.drive  = 1'b1;
                p.hi_sel = 1'b1;
                p.wr_n   = 1'b0;
            end
            ST_LOAD: begin
                p.hi_sel = 1'b1;
                p.ld_n   = 1'b0;
            end
            default: p.drive = 1'b0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/dac_seq_timer.sv
module dac_seq_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/dac_seq_fsm.sv
module dac_seq_fsm
    import dac_seq_pkg::*;
#(
    parameter int CNT_W      = 5,
    parameter int SETUP_CYC  = 1,
    parameter int STROBE_CYC = 10,
    parameter int HOLD_CYC   = 1,
    parameter int LOAD_CYC   = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             timer_expired,
    output seq_state_t       state_q,
    output seq_state_t       state_d,
    output logic             accept,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output logic             done
);
    localparam logic [CNT_W-1:0] SETUP_V  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] STROBE_V = CNT_W'(STROBE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_V   = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] LOAD_V   = CNT_W'(LOAD_CYC - 1);

    logic done_q;

    assign accept = (state_q == ST_IDLE) && in_valid;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:      if (in_valid)      state_d = ST_LO_SETUP;
            ST_LO_SETUP:  if (timer_expired) state_d = ST_LO_STROBE;
            ST_LO_STROBE: if (timer_expired) state_d = ST_LO_HOLD;
            ST_LO_HOLD:   if (timer_expired) state_d = ST_HI_SETUP;
            ST_HI_SETUP:  if (timer_expired) state_d = ST_HI_STROBE;
            ST_HI_STROBE: if (timer_expired) state_d = ST_HI_HOLD;
            ST_HI_HOLD:   if (timer_expired) state_d = ST_LOAD;
            ST_LOAD:      if (timer_expired) state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    // Each phase is entered with its length minus one in the timer
    assign timer_load = (state_d != state_q);

    always_comb begin
        case (state_d)
            ST_LO_SETUP, ST_HI_SETUP:   timer_val = SETUP_V;
            ST_LO_STROBE, ST_HI_STROBE: timer_val = STROBE_V;
            ST_LO_HOLD, ST_HI_HOLD:     timer_val = HOLD_V;
            ST_LOAD:                    timer_val = LOAD_V;
            default:                    timer_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_LOAD) && timer_expired;
        end
    end

    assign done = done_q;
endmodule

// File: rtl/dac_seq_pins.sv
module dac_seq_pins
    import dac_seq_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  accept,
    input  logic [2*BYTE_W-1:0]   in_code,
    input  seq_state_t            state_d,
    output logic [BYTE_W-1:0]     data,
    output logic                  wr_n,
    output logic                  ld_n,
    output logic                  hi_sel
);
    localparam int CODE_W = 2 * BYTE_W;

    logic [CODE_W-1:0] word_q;
    logic [CODE_W-1:0] word_nx;
    logic [BYTE_W-1:0] byte_nx;
    logic [BYTE_W-1:0] data_q;
    logic              wr_n_q;
    logic              ld_n_q;
    logic              sel_q;
    pin_ctl_t          ctl;

    assign word_nx = accept ? in_code : word_q;
    assign ctl     = pin_decode(state_d);

    for (genvar i = 0; i < BYTE_W; i++) begin : g_lane
        assign byte_nx[i] = ctl.hi_sel ? word_nx[BYTE_W + i] : word_nx[i];
    end

    // Pins are registered from the next phase so they align with the phase register
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            data_q <= '0;
            wr_n_q <= 1'b1;
            ld_n_q <= 1'b1;
            sel_q  <= 1'b0;
        end else begin
            word_q <= word_nx;
            wr_n_q <= ctl.wr_n;
            ld_n_q <= ctl.ld_n;
            if (ctl.drive) begin
                data_q <= byte_nx;
                sel_q  <= ctl.hi_sel;
            end
        end
    end

    assign data   = data_q;
    assign wr_n   = wr_n_q;
    assign ld_n   = ld_n_q;
    assign hi_sel = sel_q;
endmodule

// File: rtl/dac_byte_writer.sv
module dac_byte_writer
    import dac_seq_pkg::*;
#(
    parameter int BYTE_W        = 8,
    parameter int CLK_PERIOD_PS = 8000,
    parameter int WR_LOW_NS     = 80,
    parameter int DATA_SETUP_NS = 80,
    parameter int DATA_HOLD_NS  = 0,
    parameter int SEL_SETUP_NS  = 0,
    parameter int SEL_HOLD_NS   = 0,
    parameter int LOAD_LOW_NS   = 150
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [2*BYTE_W-1:0] in_code,
    output logic                busy,
    output logic                done,
    output logic [BYTE_W-1:0]   dac_data,
    output logic                dac_wr_n,
    output logic                dac_hi_sel,
    output logic                dac_ld_n,
    output logic                dac_clr_n
);
    localparam int SETUP_CYC  = ns_to_clocks(SEL_SETUP_NS, CLK_PERIOD_PS);
    localparam int STROBE_CYC = max_int(ns_to_clocks(WR_LOW_NS, CLK_PERIOD_PS),
                                        ns_to_clocks(DATA_SETUP_NS, CLK_PERIOD_PS));
    localparam int HOLD_CYC   = max_int(ns_to_clocks(DATA_HOLD_NS, CLK_PERIOD_PS),
                                        ns_to_clocks(SEL_HOLD_NS, CLK_PERIOD_PS));
    localparam int LOAD_CYC   = ns_to_clocks(LOAD_LOW_NS, CLK_PERIOD_PS);
    localparam int MAX_CYC    = max_int(max_int(SETUP_CYC, STROBE_CYC),
                                        max_int(HOLD_CYC, LOAD_CYC));
    localparam int CNT_W      = $clog2(MAX_CYC + 1);

    seq_state_t       state_q;
    seq_state_t       state_d;
    logic             accept;
    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    logic             timer_expired;

    dac_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (timer_load),
        .load_val (timer_val),
        .expired  (timer_expired)
    );

    dac_seq_fsm #(
        .CNT_W      (CNT_W),
        .SETUP_CYC  (SETUP_CYC),
        .STROBE_CYC (STROBE_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .LOAD_CYC   (LOAD_CYC)
    ) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .timer_expired (timer_expired),
        .state_q       (state_q),
        .state_d       (state_d),
        .accept        (accept),
        .timer_load    (timer_load),
        .timer_val     (timer_val),
        .done          (done)
    );

    dac_seq_pins #(.BYTE_W(BYTE_W)) u_pins (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .in_code (in_code),
        .state_d (state_d),
        .data    (dac_data),
        .wr_n    (dac_wr_n),
        .ld_n    (dac_ld_n),
        .hi_sel  (dac_hi_sel)
    );

    assign in_ready  = (state_q == ST_IDLE);
    assign busy      = (state_q != ST_IDLE);
    assign dac_clr_n = 1'b1;
endmodule

// File: rtl/dac_seq_checker.sv
module dac_seq_checker #(
    parameter int BYTE_W     = 8,
    parameter int STROBE_CYC = 10,
    parameter int LOAD_CYC   = 19
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              busy,
    input logic              done,
    input logic [BYTE_W-1:0] dac_data,
    input logic              dac_wr_n,
    input logic              dac_hi_sel,
    input logic              dac_ld_n,
    input logic              dac_clr_n
);
    logic [15:0] wr_low_cnt;
    logic [15:0] ld_low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_low_cnt <= '0;
            ld_low_cnt <= '0;
        end else begin
            wr_low_cnt <= dac_wr_n ? 16'd0 : wr_low_cnt + 16'd1;
            ld_low_cnt <= dac_ld_n ? 16'd0 : ld_low_cnt + 16'd1;
        end
    end

    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (busy && !in_ready));

    p_ready_with_load_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(dac_ld_n) |-> in_ready);

    p_load_after_high_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(dac_ld_n) |-> (dac_hi_sel && $past(dac_hi_sel) && dac_wr_n));

    p_wr_width_r4: assert property (@(posedge clk) disable iff (rst)
        (dac_wr_n && !$past(dac_wr_n)) |-> (wr_low_cnt == 16'(STROBE_CYC)));

    p_data_steady_r5: assert property (@(posedge clk) disable iff (rst)
        (!dac_wr_n || !$past(dac_wr_n)) |-> $stable(dac_data));

    p_sel_steady_r6: assert property (@(posedge clk) disable iff (rst)
        (!dac_wr_n || !$past(dac_wr_n)) |-> $stable(dac_hi_sel));

    p_ld_width_r7: assert property (@(posedge clk) disable iff (rst)
        (dac_ld_n && !$past(dac_ld_n)) |-> (ld_low_cnt == 16'(LOAD_CYC)));

    p_no_overlap_r7: assert property (@(posedge clk) disable iff (rst)
        !(!dac_wr_n && !dac_ld_n));

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_at_load_end_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> $rose(dac_ld_n));

    p_clear_inactive_r9: assert property (@(posedge clk) disable iff (rst)
        dac_clr_n);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (in_ready && $past(in_ready)) |->
            ($stable(dac_data) && $stable(dac_hi_sel) && dac_wr_n && dac_ld_n));
endmodule

bind dac_byte_writer dac_seq_checker #(
    .BYTE_W     (BYTE_W),
    .STROBE_CYC (STROBE_CYC),
    .LOAD_CYC   (LOAD_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .busy       (busy),
    .done       (done),
    .dac_data   (dac_data),
    .dac_wr_n   (dac_wr_n),
    .dac_hi_sel (dac_hi_sel),
    .dac_ld_n   (dac_ld_n),
    .dac_clr_n  (dac_clr_n)
);

// File: tb/tb_dac_byte_writer.sv
module tb_dac_byte_writer;
    localparam int EXP_STROBE = 10;  // ceil(80 ns / 8 ns)
    localparam int EXP_LOAD   = 19;  // ceil(150 ns / 8 ns)
    localparam int EXP_BUSY   = 1 + EXP_STROBE + 1 + 1 + EXP_STROBE + 1 + EXP_LOAD;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_code = '0;
    logic        in_ready, busy, done;
    logic [7:0]  dac_data;
    logic        dac_wr_n, dac_hi_sel, dac_ld_n, dac_clr_n;

    int n_checks = 0;
    int n_err    = 0;

    always #4 clk = ~clk;

    dac_byte_writer dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_code(in_code), .busy(busy), .done(done), .dac_data(dac_data),
        .dac_wr_n(dac_wr_n), .dac_hi_sel(dac_hi_sel), .dac_ld_n(dac_ld_n),
        .dac_clr_n(dac_clr_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural model of the converter's input and output registers
    logic [7:0]  m_lo = '0, m_hi = '0;
    logic [15:0] m_out = '0;
    logic        prev_wr, prev_ld, prev_sel, ord0, ord1;
    logic [7:0]  prev_data;
    int          wr_lo, ld_lo, data_age, sel_age, nwr;

    always @(negedge clk) begin
        if (rst) begin
            prev_wr = 1'b1; prev_ld = 1'b1; wr_lo = 0; ld_lo = 0;
            data_age = 0; sel_age = 0; nwr = 0;
            prev_data = dac_data; prev_sel = dac_hi_sel;
        end else begin
            data_age = (dac_data == prev_data) ? data_age + 1 : 1;
            sel_age  = (dac_hi_sel == prev_sel) ? sel_age + 1 : 1;
            if (prev_wr && !dac_wr_n) begin
                chk(sel_age >= 2, "R6 select setup before write fall", sel_age, 2);
                wr_lo = 1;
            end else if (!dac_wr_n) begin
                wr_lo++;
            end
            if (!prev_wr && dac_wr_n) begin
                chk(wr_lo == EXP_STROBE, "R4 write low width", wr_lo, EXP_STROBE);
                chk(data_age >= EXP_STROBE + 1, "R5 data setup and hold", data_age, EXP_STROBE + 1);
                chk(sel_age >= EXP_STROBE + 1, "R6 select hold after write rise", sel_age, EXP_STROBE + 1);
                if (dac_hi_sel) m_hi = dac_data; else m_lo = dac_data;
                if (nwr == 0) ord0 = dac_hi_sel; else if (nwr == 1) ord1 = dac_hi_sel;
                nwr++;
            end
            if (prev_ld && !dac_ld_n) begin
                chk(nwr == 2, "R3 two writes per load", nwr, 2);
                chk(ord0 == 1'b0 && ord1 == 1'b1, "R3 low byte then high byte", {ord0, ord1}, 2'b01);
                chk(dac_wr_n && dac_hi_sel, "R7 load starts after final write", {dac_wr_n, dac_hi_sel}, 2'b11);
                m_out = {m_hi, m_lo};
                nwr   = 0;
                ld_lo = 1;
            end else if (!dac_ld_n) begin
                ld_lo++;
            end
            if (!prev_ld && dac_ld_n) begin
                chk(ld_lo == EXP_LOAD, "R7 load low width", ld_lo, EXP_LOAD);
            end
            prev_wr = dac_wr_n; prev_ld = dac_ld_n;
            prev_data = dac_data; prev_sel = dac_hi_sel;
        end
    end

    task automatic t_reset();
        chk(dac_wr_n && dac_ld_n && dac_clr_n, "R1 strobes high after reset",
            {dac_wr_n, dac_ld_n, dac_clr_n}, 3'b111);
        chk(dac_data == 8'h00, "R1 data zero after reset", dac_data, 0);
        chk(in_ready && !busy && !done, "R1 handshake idle after reset",
            {in_ready, busy, done}, 3'b100);
    endtask

    task automatic wait_done(output int n, output int bad);
        n = 0; bad = 0;
        while (!done && n < 200) begin
            if (in_ready) bad++;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run_word(input logic [15:0] code);
        int n, bad;
        @(negedge clk);
        chk(in_ready, "R2 ready before request", in_ready, 1);
        in_valid = 1'b1; in_code = code;
        @(negedge clk);
        in_valid = 1'b0;
        chk(!in_ready && busy, "R2 ready drops after accept", {in_ready, busy}, 2'b01);
        wait_done(n, bad);
        chk(n == EXP_BUSY, "R2 busy length", n, EXP_BUSY);
        chk(bad == 0, "R2 ready stays low while busy", bad, 0);
        chk(in_ready && dac_ld_n && done, "R8 done with load high and ready",
            {in_ready, dac_ld_n, done}, 3'b111);
        chk(m_out == code, "R3 converter receives word", m_out, code);
        @(negedge clk);
        chk(!done, "R8 done lasts one cycle", done, 0);
    endtask

    task automatic t_codes();
        run_word(16'h1234);
        run_word(16'h0000);
        run_word(16'hFFFF);
        run_word(16'h8000);
        run_word(16'h7FFF);
    endtask

    task automatic t_ignore_busy();
        int n, bad, starts;
        @(negedge clk);
        in_valid = 1'b1; in_code = 16'hA55A;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (5) @(negedge clk);
        in_valid = 1'b1; in_code = 16'h0F0F;
        repeat (10) @(negedge clk);
        in_valid = 1'b0; in_code = 16'hFFFF;
        wait_done(n, bad);
        chk(m_out == 16'hA55A, "R10 busy changes ignored", m_out, 16'hA55A);
        starts = 0;
        repeat (6) begin
            @(negedge clk);
            if (!in_ready || !dac_wr_n) starts++;
        end
        chk(starts == 0, "R10 withdrawn request starts nothing", starts, 0);
    endtask

    task automatic t_idle_hold();
        int bad;
        bad = 0;
        repeat (20) begin
            @(negedge clk);
            if (dac_data != 8'hA5 || !dac_hi_sel || !dac_wr_n || !dac_ld_n || !dac_clr_n) bad++;
        end
        chk(bad == 0, "R9 idle holds last high byte and strobes", bad, 0);
    endtask

    task automatic t_back_to_back();
        int n, bad;
        @(negedge clk);
        in_valid = 1'b1; in_code = 16'h3C81;
        @(negedge clk);
        in_code = 16'hC37E;
        wait_done(n, bad);
        chk(m_out == 16'h3C81, "R2 first of back-to-back", m_out, 16'h3C81);
        chk(in_ready, "R2 ready at load end", in_ready, 1);
        @(negedge clk);
        chk(!in_ready && busy, "R2 held request accepted at once", {in_ready, busy}, 2'b01);
        in_valid = 1'b0;
        wait_done(n, bad);
        chk(n == EXP_BUSY, "R2 second busy length", n, EXP_BUSY);
        chk(m_out == 16'hC37E, "R2 second of back-to-back", m_out, 16'hC37E);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_checks++;
        $display("FAIL watchdog R2 actual=hung expected=finish");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_codes();
        t_ignore_busy();
        t_idle_hold();
        t_back_to_back();
        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule